// File: doc/BRIEF.md
# PWM Counter Interrupt Event Generator

This block holds the time base of one PWM channel and turns selected moments of its count into interrupt requests. The counter either runs as a down counter that reloads from a period value, or as an up/down counter that climbs from zero to the period value and then falls back. In every cycle the block compares the count with zero, with the period value and with two compare thresholds. The two compare matches are also split by counting direction, which gives six event sources.

Each source has its own enable bit in a small register. An enabled event sets a sticky raw status bit, and the interrupt line is high while any status bit is set. Software reads both registers through a one-bit-address register port and acknowledges events by writing ones to the status address. Period, threshold and mode inputs are sampled only when the count reaches zero, so each period runs on a consistent set of values.

Top module: `pwm_evt_irq`

## Requirements
- R1: Event sources map to bit positions as follows: bit 0 count is zero, bit 1 count equals the period value, bit 2 count equals threshold A while rising, bit 3 count equals threshold A while falling, bit 4 count equals threshold B while rising, bit 5 count equals threshold B while falling. The same positions are used in the enable register and in the raw status. An enabled event sets its status bit at the clock edge that ends the matching cycle.
- R2: An event whose enable bit is 0 never sets its status bit. Any mix of enable bits may be set together.
- R3: After reset the enable register, the raw status and the interrupt line are all zero.
- R4: Register address 0 is the enable register. Bits 31:6 read as zero and ignore writes, while bits 5:0 read back what was written. Reading address 1 returns the raw status in bits 5:0, with zero above.
- R5: When up/down mode is selected (ud_mode = 1), the count goes 0, 1, … P, P−1, … 1, 0 and repeats, visiting each value once per pass. At zero it counts as rising and at P as falling, so a threshold equal to P gives only the falling event and a threshold of 0 gives only the rising event.
- R6: When down-only mode is selected (ud_mode = 0), the count goes P, P−1, … 0 and then reloads P. All matches in this mode count as falling, so bits 2 and 4 are never set.
- R7: A threshold larger than the period value never produces a compare event.
- R8: Status bits are sticky. A write to address 1 clears exactly those status bits whose data bit is 1.
- R9: If an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: irq is 1 exactly when at least one raw status bit is 1.
- R11: The period, threshold and mode inputs are taken into use at the clock edge that ends a cycle in which the count is zero. A change made during a period has no effect until that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| period | input | CW | Period (top or reload) value, nonzero |
| thr_a | input | CW | Compare threshold A |
| thr_b | input | CW | Compare threshold B |
| ud_mode | input | 1 | 1 = up/down counting, 0 = down-only |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable register, 1 = status (write 1 to clear) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| raw_stat | output | 6 | Sticky raw event status |
| irq | output | 1 | Interrupt request, OR of raw_stat |

## Verification
The hardest cases to reach from the ports are the clear that meets a new event in the same cycle and the threshold change made in the middle of a period, because the counter itself is not visible. The bench enables only the zero event and uses the rising edge of the status bit as a phase marker. From that marker it counts clock edges to the next zero match, and it places the clear write or the threshold change on an exact edge relative to it. A vector table covers both counting modes and checks which direction-qualified events each threshold placement produces.

// File: rtl/pwm_evt_irq.sv
module pwm_evt_irq #(
  parameter int CW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] thr_a,
  input  logic [CW-1:0] thr_b,
  input  logic          ud_mode,
  input  logic          reg_we,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [5:0]    raw_stat,
  output logic          irq
);

  localparam int NEV = 6;

  logic [CW-1:0]  cnt, per_q, ta_q, tb_q;
  logic           ud_q, fell_q;
  logic [NEV-1:0] en_q, hit, clr, keep;
  logic           at_zero, at_top, falling;
  logic           unused_wbits;

  assign unused_wbits = &{1'b0, reg_wdata[DW-1:NEV]};

  assign at_zero = (cnt == '0);
  assign at_top  = (cnt == per_q);
  assign falling = !ud_q || at_top || (!at_zero && fell_q);

  assign hit[0] = at_zero;
  assign hit[1] = at_top;
  assign hit[2] = !falling && (cnt == ta_q);
  assign hit[3] =  falling && (cnt == ta_q);
  assign hit[4] = !falling && (cnt == tb_q);
  assign hit[5] =  falling && (cnt == tb_q);

  assign clr  = (reg_we && reg_addr) ? reg_wdata[NEV-1:0] : '0;
  assign keep = raw_stat & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= '0;
      ta_q   <= '0;
      tb_q   <= '0;
      ud_q   <= 1'b0;
      fell_q <= 1'b0;
    end else if (at_zero) begin
      per_q  <= period;
      ta_q   <= thr_a;
      tb_q   <= thr_b;
      ud_q   <= ud_mode;
      cnt    <= ud_mode ? ((period != '0) ? CW'(1) : '0) : period;
      fell_q <= !ud_mode;
    end else if (falling) begin
      cnt    <= cnt - CW'(1);
      fell_q <= 1'b1;
    end else begin
      cnt    <= cnt + CW'(1);
      fell_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      raw_stat <= '0;
    end else begin
      if (reg_we && !reg_addr) en_q <= reg_wdata[NEV-1:0];
      raw_stat <= keep | (hit & en_q);
    end
  end

  assign irq       = |raw_stat;
  assign reg_rdata = {{(DW-NEV){1'b0}}, reg_addr ? raw_stat : en_q};

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_stat & $past(keep)) == $past(keep)));

  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_stat & ~$past(raw_stat) & ~$past(en_q)) == '0));

  p_no_rise_in_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ud_q |-> (!hit[2] && !hit[4]));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_q);

  p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> ($stable(per_q) && $stable(ta_q) && $stable(tb_q) && $stable(ud_q)));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & en_q & clr)) |=> ((raw_stat & $past(hit & en_q & clr)) == $past(hit & en_q & clr)));

endmodule

// File: tb/pwm_evt_irq_test.sv
`timescale 1ns/1ps
module pwm_evt_irq_test;
  localparam int CW = 8;
  localparam real TCK = 4.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] period = 8'd5, thr_a = 8'd20, thr_b = 8'd20;
  logic          ud_mode = 1'b0;
  logic          reg_we = 1'b0, reg_addr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [5:0]    raw_stat;
  logic          irq;

  int checks = 0, errors = 0;

  always #(TCK/2) clk = ~clk;

  pwm_evt_irq #(.CW(CW), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .period(period), .thr_a(thr_a), .thr_b(thr_b),
    .ud_mode(ud_mode), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_stat(raw_stat), .irq(irq));

  // {ud, period, thr_a, thr_b, 2'b0, enable, 2'b0, expected}
  localparam int NV = 9;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'd10, 8'd4,  8'd7, 2'b0, 6'h3F, 2'b0, 6'h3F},
    {1'b0, 8'd10, 8'd4,  8'd7, 2'b0, 6'h3F, 2'b0, 6'h2B},
    {1'b1, 8'd10, 8'd10, 8'd0, 2'b0, 6'h3F, 2'b0, 6'h1B},
    {1'b1, 8'd6,  8'd20, 8'd3, 2'b0, 6'h3C, 2'b0, 6'h30},
    {1'b0, 8'd5,  8'd0,  8'd5, 2'b0, 6'h2A, 2'b0, 6'h2A},
    {1'b1, 8'd12, 8'd2,  8'd9, 2'b0, 6'h14, 2'b0, 6'h14},
    {1'b0, 8'd12, 8'd2,  8'd9, 2'b0, 6'h14, 2'b0, 6'h00},
    {1'b1, 8'd1,  8'd1,  8'd0, 2'b0, 6'h3F, 2'b0, 6'h1B},
    {1'b0, 8'd1,  8'd1,  8'd0, 2'b0, 6'h3F, 2'b0, 6'h2B}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wait_zero_mark;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (raw_stat[0]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    // R3: reset state, counter running with nothing enabled
    check("R3 raw_stat", 32'(raw_stat), 32'h0);
    check("R3 irq", 32'(irq), 32'h0);
    rd(1'b0, d);
    check("R3 enable", d, 32'h0);

    // R4: reserved enable bits
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d);
    check("R4 enable readback", d, 32'h0000_003F);
    wr(1'b0, 32'h0);

    // R1 R2 R5 R6 R7 R10: vector table
    for (int k = 0; k < NV; k++) begin
      wr(1'b0, 32'h0);
      @(negedge clk);
      ud_mode = VEC[k][40];
      period  = VEC[k][39:32];
      thr_a   = VEC[k][31:24];
      thr_b   = VEC[k][23:16];
      repeat (60) @(negedge clk);
      wr(1'b1, 32'h3F);
      wr(1'b0, {26'b0, VEC[k][13:8]});
      repeat (60) @(negedge clk);
      rd(1'b1, d);
      check($sformatf("R1 R2 R5 R6 R7 vector %0d status", k), d, {26'b0, VEC[k][5:0]});
      check($sformatf("R10 vector %0d irq", k), 32'(irq), 32'(|VEC[k][5:0]));
    end

    // R9 and R8: clear meeting an event, then a plain clear
    wr(1'b0, 32'h0);
    @(negedge clk);
    ud_mode = 1'b0; period = 8'd3; thr_a = 8'd20; thr_b = 8'd20;
    repeat (40) @(negedge clk);
    wr(1'b1, 32'h3F);
    wr(1'b0, 32'h01);
    wait_zero_mark();
    repeat (3) @(negedge clk);
    reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h01;
    @(negedge clk);
    check("R9 set wins over clear", 32'(raw_stat[0]), 32'h1);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    check("R8 write-one clear", 32'(raw_stat[0]), 32'h0);

    // R11: mid-period threshold change waits for the zero point
    wr(1'b0, 32'h0);
    @(negedge clk);
    period = 8'd8; thr_a = 8'd20;
    repeat (40) @(negedge clk);
    wr(1'b1, 32'h3F);
    wr(1'b0, 32'h01);
    wait_zero_mark();
    reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h08;
    @(negedge clk);
    reg_addr = 1'b1; reg_wdata = 32'h01;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    thr_a = 8'd5;
    repeat (10) @(negedge clk);
    check("R11 no match before zero point", 32'(raw_stat), 32'h0);
    @(negedge clk);
    check("R11 match after zero point", 32'(raw_stat), 32'h08);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule